// File: doc/BRIEF.md
# Store Queue with Exact-Match Forwarding

This block buffers stores between the store address port and the data cache and checks every load against the stores it holds. Stores enter in program order, wait until the retirement side marks them committed, and then leave for the cache one per cycle, oldest first. A load arriving on the separate load port is compared with every store still held. When the youngest store that touches any of the load's bytes has the same address and the same size, its data goes straight back to the load. Any other overlap holds the load off, with ready low, until that store has left.

Forwarding hardware stays small because only the exact, naturally aligned case is served. An access whose address is not a multiple of its size is never executed. It is turned into a trap report so that software can emulate it, and both ports stay closed until the trap is acknowledged. A flush throws away every store not yet committed, while committed stores keep draining.

Top module: `store_queue_top`

## Requirements
- R1: After reset the queue is empty: stReady and ldReady are 1, drainValid and trapValid are 0.
- R2: Aligned stores accepted with stValid and stReady are held in arrival order; stReady is 0 while DEPTH stores are held.
- R3: drainAddr, drainSize and drainData show the oldest held store; one store leaves per cycle in which drainValid and drainReady are both 1.
- R4: A load whose youngest overlapping held store has the same address and size gets ldReady=1, ldFwd=1 and that store's data on ldFwdData.
- R5: When several held stores overlap a load, only the youngest decides: it forwards when it matches exactly, and the load stalls when it does not, even if an older store matches exactly.
- R6: A load whose youngest overlapping store differs in address or size sees ldReady=0 until that store has drained.
- R7: A load overlapping no held store gets ldReady=1 and ldFwd=0; a store offered in the same cycle counts as younger and is not checked against it.
- R8: Sizes are coded 0=byte, 1=half-word, 2=word, 3=double-word; an access is aligned when its address is a multiple of its size. An accepted misaligned load sets trapValid=1, trapIsLoad=1, trapAddr to its address; stReady is 0 in that cycle.
- R9: An accepted misaligned store sets trapValid=1, trapIsLoad=0, trapAddr to its address and is not queued.
- R10: While trapValid is 1, stReady and ldReady are 0 and the trap report is held; trapValid falls in the cycle after trapAck.
- R11: In a flush cycle no store is accepted and every uncommitted store is discarded; committed stores still drain.
- R12: Each commitValid cycle (without flush) marks the oldest uncommitted held store committed and is ignored when none exists; drainValid is 1 exactly when a committed store is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Store port accepts this cycle |
| stAddr | input | AW | Store byte address |
| stSize | input | 2 | Store size code |
| stData | input | DW | Store data |
| ldValid | input | 1 | Load offered |
| ldReady | output | 1 | Load may proceed this cycle |
| ldAddr | input | AW | Load byte address |
| ldSize | input | 2 | Load size code |
| ldFwd | output | 1 | Load data comes from the queue |
| ldFwdData | output | DW | Forwarded store data |
| commitValid | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard uncommitted stores |
| drainValid | output | 1 | A committed store is ready for the cache |
| drainReady | input | 1 | Cache takes the oldest store |
| drainAddr | output | AW | Address of oldest store |
| drainSize | output | 2 | Size of oldest store |
| drainData | output | DW | Data of oldest store |
| trapValid | output | 1 | Misalignment trap pending |
| trapIsLoad | output | 1 | Pending trap came from a load |
| trapAddr | output | AW | Address that trapped |
| trapAck | input | 1 | Trap has been taken |

## Verification
The bench aims at loads covered by more than one store, where a design that scanned oldest-first would forward stale data or stall on a store that an exact younger match hides. It holds a stalled load across drain cycles, so a design that released it early or never would disagree with the model in a specific cycle. Misaligned loads and stores are offered alongside legal traffic on the other port, catching a design that queues a trapping store or lets a younger store slip in during a load trap. Flushes land while stores are part-committed, exposing a queue that drops committed stores or keeps uncommitted ones.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  // Strobes from the control to the datapath, one per state change.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } sfqStrobe_t;

  // Size code: 0 byte, 1 half, 2 word, 3 double.
  function automatic logic isAligned(input logic [2:0] low, input logic [1:0] size);
    logic ok;
    case (size)
      2'd0:    ok = 1'b1;
      2'd1:    ok = (low[0] == 1'b0);
      2'd2:    ok = (low[1:0] == 2'b00);
      default: ok = (low == 3'b000);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sfq_data.sv
module sfq_data
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sfqStrobe_t    strobe,
  input  logic [AW-1:0] stAddr,
  input  logic [1:0]    stSize,
  input  logic [DW-1:0] stData,
  input  logic [CW-1:0] liveCnt,
  input  logic [CW-1:0] keepCnt,
  input  logic [AW-1:0] ldAddr,
  input  logic [1:0]    ldSize,
  output logic          hitAny,
  output logic          hitExact,
  output logic [DW-1:0] fwdData,
  output logic [AW-1:0] drainAddr,
  output logic [1:0]    drainSize,
  output logic [DW-1:0] drainData
);

  logic [AW-1:0] entAddr [DEPTH];
  logic [1:0]    entSize [DEPTH];
  logic [DW-1:0] entData [DEPTH];

  logic [PW-1:0] head, tail, headNxt;

  assign headNxt = head + PW'(strobe.pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= headNxt;
      if (strobe.flush)
        tail <= PW'(CW'(headNxt) + keepCnt);
      else if (strobe.push)
        tail <= tail + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      entAddr[tail] <= stAddr;
      entSize[tail] <= stSize;
      entData[tail] <= stData;
    end
  end

  // Byte ranges [a, a + 2^size) intersect.
  function automatic logic rangesMeet(input logic [AW-1:0] aA, input logic [1:0] sA,
                                      input logic [AW-1:0] aB, input logic [1:0] sB);
    logic [AW:0] loA, hiA, loB, hiB;
    loA = {1'b0, aA};
    loB = {1'b0, aB};
    hiA = loA + ((AW+1)'(1) << sA);
    hiB = loB + ((AW+1)'(1) << sB);
    return (loA < hiB) && (loB < hiA);
  endfunction

  // Scan oldest to youngest; the last overlap found is the youngest.
  always_comb begin
    hitAny   = 1'b0;
    hitExact = 1'b0;
    fwdData  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(i);
      if ((CW'(i) < liveCnt) && rangesMeet(entAddr[idx], entSize[idx], ldAddr, ldSize)) begin
        hitAny   = 1'b1;
        hitExact = (entAddr[idx] == ldAddr) && (entSize[idx] == ldSize);
        fwdData  = entData[idx];
      end
    end
  end

  assign drainAddr = entAddr[head];
  assign drainSize = entSize[head];
  assign drainData = entData[head];

endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stValid,
  input  logic          stMis,
  input  logic [AW-1:0] stAddr,
  input  logic          ldValid,
  input  logic          ldMis,
  input  logic [AW-1:0] ldAddr,
  input  logic          hitAny,
  input  logic          hitExact,
  input  logic          commitValid,
  input  logic          flush,
  input  logic          drainReady,
  input  logic          trapAck,
  output sfqStrobe_t    strobe,
  output logic [CW-1:0] liveCnt,
  output logic [CW-1:0] keepCnt,
  output logic          stReady,
  output logic          ldReady,
  output logic          ldFwd,
  output logic          drainValid,
  output logic          trapValid,
  output logic          trapIsLoad,
  output logic [AW-1:0] trapAddr
);

  logic [CW-1:0] count, cmtCnt;
  logic full, stFire, pushDo, popDo, commitDo, ldTrap, stTrap;

  assign full     = (count == CW'(DEPTH));
  // A misaligned load is older than a same-cycle store, so the store waits.
  assign stReady  = !trapValid && !flush && !full && !(ldValid && ldMis);
  assign ldReady  = !trapValid && (ldMis || !hitAny || hitExact);
  assign ldFwd    = ldValid && !trapValid && !ldMis && hitAny && hitExact;

  assign stFire   = stValid && stReady;
  assign pushDo   = stFire && !stMis;
  assign stTrap   = stFire && stMis;
  assign ldTrap   = ldValid && ldMis && !trapValid;

  assign drainValid = (cmtCnt != '0);
  assign popDo      = drainValid && drainReady;
  assign commitDo   = commitValid && !flush && (cmtCnt < count);
  assign keepCnt    = cmtCnt - CW'(popDo);
  assign liveCnt    = count;

  assign strobe.push  = pushDo;
  assign strobe.pop   = popDo;
  assign strobe.flush = flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      cmtCnt <= '0;
    end else begin
      if (flush)
        count <= keepCnt;
      else
        count <= count + CW'(pushDo) - CW'(popDo);
      cmtCnt <= cmtCnt + CW'(commitDo) - CW'(popDo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trapValid  <= 1'b0;
      trapIsLoad <= 1'b0;
      trapAddr   <= '0;
    end else if (trapValid) begin
      if (trapAck) trapValid <= 1'b0;
    end else if (ldTrap) begin
      trapValid  <= 1'b1;
      trapIsLoad <= 1'b1;
      trapAddr   <= ldAddr;
    end else if (stTrap) begin
      trapValid  <= 1'b1;
      trapIsLoad <= 1'b0;
      trapAddr   <= stAddr;
    end
  end

endmodule

// File: rtl/store_queue_top.sv
module store_queue_top
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [1:0]    stSize,
  input  logic [DW-1:0] stData,
  input  logic          ldValid,
  output logic          ldReady,
  input  logic [AW-1:0] ldAddr,
  input  logic [1:0]    ldSize,
  output logic          ldFwd,
  output logic [DW-1:0] ldFwdData,
  input  logic          commitValid,
  input  logic          flush,
  output logic          drainValid,
  input  logic          drainReady,
  output logic [AW-1:0] drainAddr,
  output logic [1:0]    drainSize,
  output logic [DW-1:0] drainData,
  output logic          trapValid,
  output logic          trapIsLoad,
  output logic [AW-1:0] trapAddr,
  input  logic          trapAck
);

  sfqStrobe_t    strobe;
  logic [CW-1:0] liveCnt, keepCnt;
  logic          hitAny, hitExact, stMis, ldMis;

  assign stMis = !isAligned(stAddr[2:0], stSize);
  assign ldMis = !isAligned(ldAddr[2:0], ldSize);

  sfq_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .stValid(stValid), .stMis(stMis), .stAddr(stAddr),
    .ldValid(ldValid), .ldMis(ldMis), .ldAddr(ldAddr),
    .hitAny(hitAny), .hitExact(hitExact),
    .commitValid(commitValid), .flush(flush), .drainReady(drainReady), .trapAck(trapAck),
    .strobe(strobe), .liveCnt(liveCnt), .keepCnt(keepCnt),
    .stReady(stReady), .ldReady(ldReady), .ldFwd(ldFwd), .drainValid(drainValid),
    .trapValid(trapValid), .trapIsLoad(trapIsLoad), .trapAddr(trapAddr)
  );

  sfq_data #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) data_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .stAddr(stAddr), .stSize(stSize), .stData(stData),
    .liveCnt(liveCnt), .keepCnt(keepCnt),
    .ldAddr(ldAddr), .ldSize(ldSize),
    .hitAny(hitAny), .hitExact(hitExact), .fwdData(ldFwdData),
    .drainAddr(drainAddr), .drainSize(drainSize), .drainData(drainData)
  );

endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stValid,
  input logic          stReady,
  input logic [AW-1:0] stAddr,
  input logic [1:0]    stSize,
  input logic          ldValid,
  input logic          ldReady,
  input logic [AW-1:0] ldAddr,
  input logic [1:0]    ldSize,
  input logic          ldFwd,
  input logic          flush,
  input logic          drainValid,
  input logic          drainReady,
  input logic [AW-1:0] drainAddr,
  input logic [DW-1:0] drainData,
  input logic          trapValid,
  input logic          trapIsLoad,
  input logic [AW-1:0] trapAddr,
  input logic          trapAck
);

  logic stMisC, ldMisC;
  assign stMisC = !sfq_pkg::isAligned(stAddr[2:0], stSize);
  assign ldMisC = !sfq_pkg::isAligned(ldAddr[2:0], ldSize);

  a_r10_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trapValid |-> (!stReady && !ldReady));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && trapAck) |=> !trapValid);

  a_r10_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && !trapAck) |=> (trapValid && $stable(trapAddr) && $stable(trapIsLoad)));

  a_r8_load_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && ldMisC && !trapValid) |=> (trapValid && trapIsLoad && trapAddr == $past(ldAddr)));

  a_r9_store_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (stValid && stReady && stMisC) |=> (trapValid && !trapIsLoad && trapAddr == $past(stAddr)));

  a_r3_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drainValid && !drainReady) |=> (drainValid && $stable(drainAddr) && $stable(drainData)));

  a_r11_flush_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !stReady);

  a_r4_fwd_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    ldFwd |-> (ldValid && ldReady && !ldMisC));

endmodule

bind store_queue_top sfq_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/store_queue_top_tb_top.sv
`timescale 1ns/1ps
module store_queue_top_tb_top;

  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stValid = 0, ldValid = 0, commitValid = 0, flush = 0, drainReady = 0, trapAck = 0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [1:0] stSize = '0, ldSize = '0;
  logic [DW-1:0] stData = '0;
  logic stReady, ldReady, ldFwd, drainValid, trapValid, trapIsLoad;
  logic [DW-1:0] ldFwdData, drainData;
  logic [AW-1:0] drainAddr, trapAddr;
  logic [1:0] drainSize;

  always #2 clk = ~clk;

  store_queue_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (.*);

  int nChecks = 0, nErr = 0, cycles = 0;
  bit done = 0;

  typedef struct { logic [AW-1:0] a; logic [1:0] s; logic [DW-1:0] d; } ent_t;
  ent_t mq[$];
  int mCmt = 0;
  bit mTrap = 0, mTrapLd = 0;
  logic [AW-1:0] mTrapAddr = '0;

  function automatic bit al(logic [AW-1:0] a, logic [1:0] s);
    return (a % (1 << s)) == 0;
  endfunction

  function automatic bit ov(logic [AW-1:0] a1, logic [1:0] s1, logic [AW-1:0] a2, logic [1:0] s2);
    longint l1 = longint'(a1), l2 = longint'(a2);
    return (l1 < l2 + (1 << s2)) && (l2 < l1 + (1 << s1));
  endfunction

  task automatic ck(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: compare at the falling edge, then advance to the next rising edge.
  always @(negedge clk) begin : model
    int young, nOv;
    bit ldMis, stMis, expSt, expLd, expFwd, exact, commitDo, pop, push;
    string lt;
    if (!rst_n) begin
      mq.delete(); mCmt = 0; mTrap = 0;
    end else if (!done) begin
      ldMis = !al(ldAddr, ldSize);
      stMis = !al(stAddr, stSize);
      young = -1; nOv = 0;
      foreach (mq[i]) if (ov(mq[i].a, mq[i].s, ldAddr, ldSize)) begin young = i; nOv++; end
      exact = (young >= 0) && mq[young].a == ldAddr && mq[young].s == ldSize;
      expSt = !mTrap && !flush && mq.size() < DEPTH && !(ldValid && ldMis);
      expLd = !mTrap && (ldMis || young < 0 || exact);
      expFwd = ldValid && !mTrap && !ldMis && exact;
      lt = mTrap ? "R10" : ldMis ? "R8" : (young < 0) ? "R7" : (nOv > 1) ? "R5" : exact ? "R4" : "R6";
      ck(mTrap ? "R10" : flush ? "R11" : (ldValid && ldMis) ? "R8" : "R2", "stReady", stReady, expSt);
      ck(lt, "ldReady", ldReady, expLd);
      ck(lt, "ldFwd", ldFwd, expFwd);
      if (expFwd) ck(lt, "ldFwdData", ldFwdData, mq[young].d);
      ck("R12", "drainValid", drainValid, mCmt > 0);
      if (mCmt > 0) begin
        ck("R3", "drainAddr", drainAddr, mq[0].a);
        ck("R3", "drainSize", drainSize, mq[0].s);
        ck("R3", "drainData", drainData, mq[0].d);
      end
      ck(mTrap ? (mTrapLd ? "R8" : "R9") : "R10", "trapValid", trapValid, mTrap);
      if (mTrap) begin
        ck(mTrapLd ? "R8" : "R9", "trapIsLoad", trapIsLoad, mTrapLd);
        ck(mTrapLd ? "R8" : "R9", "trapAddr", trapAddr, mTrapAddr);
      end
      // advance
      commitDo = commitValid && !flush && mCmt < mq.size();
      pop = (mCmt > 0) && drainReady;
      push = stValid && expSt && !stMis;
      if (pop) begin void'(mq.pop_front()); mCmt--; end
      if (flush) begin
        while (mq.size() > mCmt) void'(mq.pop_back());
      end else begin
        if (commitDo) mCmt++;
        if (push) mq.push_back('{stAddr, stSize, stData});
      end
      if (mTrap) begin
        if (trapAck) mTrap = 0;
      end else if (ldValid && ldMis) begin
        mTrap = 1; mTrapLd = 1; mTrapAddr = ldAddr;
      end else if (stValid && expSt && stMis) begin
        mTrap = 1; mTrapLd = 0; mTrapAddr = stAddr;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic clr(); stValid = 0; ldValid = 0; commitValid = 0; flush = 0; trapAck = 0; endtask
  task automatic st(logic [AW-1:0] a, logic [1:0] s, logic [DW-1:0] d);
    stValid = 1; stAddr = a; stSize = s; stData = d;
  endtask
  task automatic ld(logic [AW-1:0] a, logic [1:0] s);
    ldValid = 1; ldAddr = a; ldSize = s;
  endtask
  task automatic one(); step(); clr(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    ck("R1", "stReady after reset", stReady, 1);
    ck("R1", "ldReady after reset", ldReady, 1);
    ck("R1", "drainValid after reset", drainValid, 0);
    ck("R1", "trapValid after reset", trapValid, 0);
    step();

    // R2: three aligned stores, no drain
    st(32'h100, 3, 64'hA1A1_0000_0000_00A1); one();
    st(32'h108, 2, 64'hB2); one();
    st(32'h10C, 2, 64'hC3); one();
    // R4 exact, R6 partial, R7 none
    ld(32'h100, 3); one();
    ld(32'h108, 2); one();
    ld(32'h104, 2); one();
    ld(32'h200, 2); one();
    ld(32'h10C, 1); one();
    // R5 youngest decides
    st(32'h100, 2, 64'hD4); one();
    ld(32'h100, 3); one();
    ld(32'h100, 2); one();
    ld(32'h104, 2); one();
    // R7 same-cycle store is younger
    st(32'h300, 2, 64'hE5); ld(32'h300, 2); one();
    // R6 stall held until the blocking store drains
    drainReady = 1;
    ld(32'h104, 1); commitValid = 1; step();
    commitValid = 0; repeat (3) step();
    clr();
    // R12 commit the rest and drain
    commitValid = 1; repeat (6) step(); clr(); repeat (2) step();
    // R2 fill to capacity
    drainReady = 0;
    for (int i = 0; i < DEPTH; i++) begin st(32'h400 + 8 * i, 3, 64'h40 + i); one(); end
    st(32'h500, 3, 64'h99); repeat (2) step(); clr();
    // R11 flush with three committed
    commitValid = 1; repeat (3) step(); clr();
    flush = 1; st(32'h508, 3, 64'h77); one();
    drainReady = 1; repeat (5) step();
    // R8 misaligned load with a legal store alongside
    ld(32'h501, 2); st(32'h600, 2, 64'h11); step();
    repeat (3) step();
    trapAck = 1; step(); clr(); step();
    // R9 misaligned store
    st(32'h602, 3, 64'h22); one();
    st(32'h608, 3, 64'h33); ld(32'h700, 0); repeat (2) step(); clr();
    trapAck = 1; one(); step();
    // R12 commit ignored when nothing uncommitted
    commitValid = 1; one();
    st(32'h800, 2, 64'h44); one(); repeat (2) step();
    commitValid = 1; one(); repeat (2) step();

    // random traffic in a small window
    for (int c = 0; c < 4000; c++) begin
      logic [1:0] s;
      logic [AW-1:0] a;
      s = 2'($urandom); a = 32'($urandom % 64); a = a & ~((32'd1 << s) - 1);
      if ($urandom % 40 == 0) a = a | 1;
      stValid = ($urandom % 2) == 0; stAddr = a; stSize = s; stData = {$urandom, $urandom};
      s = 2'($urandom); a = 32'($urandom % 64); a = a & ~((32'd1 << s) - 1);
      if ($urandom % 40 == 0) a = a | 1;
      ldValid = ($urandom % 2) == 0; ldAddr = a; ldSize = s;
      commitValid = ($urandom % 3) != 0;
      drainReady = ($urandom % 2) == 0;
      flush = ($urandom % 50) == 0;
      trapAck = trapValid && (($urandom % 3) == 0);
      step();
    end
    clr(); step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule